// File: doc/BRIEF.md
# Trace Packet Serializer

This block turns trace events written by software into packets on a two-wire serial line: a bit clock and a data line. It has three trace channels. Each channel has a command register and four 16-bit parameters. A single command write gives an 8-bit header and a parameter count, and queues one packet for that channel. A fixed-priority arbiter picks one queued channel whenever the shift engine is idle. At that moment the header, the parameters and an optional 16-bit timestamp are latched. The command fields then clear themselves.

The timestamp comes from a free-running 16-bit timer. The timer counts system clock cycles, and software zeroes it by writing a one to a pulse bit in the configuration word. The bit clock half-period is a programmable number of system cycles, from one to four. The register bus accepts a write in every cycle it is presented. Reads return data combinationally from the address. Neither the bus nor the serial line has back-pressure: a receiver must keep up with the bit clock. The `busy` pin is high while any packet is queued or being sent.

Top module: `trace_serializer`

## Requirements
- R1: After reset every register reads 0, `ser_clk` and `ser_data` are low and `busy` is low.
- R2: The configuration word at byte address 0x00 holds channel 1 enable in bit 0, the channel 2 enable in bits 2:1, the channel 3 enable in bits 4:3, the timestamp enable in bit 5 and the prescaler in bits 8:7. All other bits, bit 6 included, read 0.
- R3: With prescaler value P, each phase of `ser_clk` lasts P+1 system cycles, so successive rising edges of `ser_clk` are 2*(P+1) cycles apart.
- R4: Writing the configuration word with bit 6 set zeroes the timer, which otherwise advances by one each cycle. A packet carries the timer value seen in the cycle its packet is accepted. If a clear lands in that same cycle, the packet carries 0.
- R5: A command write to a channel whose enable field is zero has no effect: the register still reads 0 and no packet is sent.
- R6: A command register (channel n at 0x04+4*(n-1)) reads the header in bits 15:8 and the count in bits 2:0 while its packet waits. It reads 0 once the packet has been accepted.
- R7: A packet is sent MSB first on each rising edge of `ser_clk`. It is the header, then the 16-bit timestamp if bit 5 is set, then parameters 0 up to count-1.
- R8: A count above 4 sends four parameters. A count of 0 sends only the header (and timestamp if enabled).
- R9: When several channels are queued, channel 1 goes first, then channel 2, then channel 3.
- R10: Parameters are latched at acceptance. Writes to the parameter registers during transmission do not change the packet being sent.
- R11: A command write to a channel that already has a packet queued is dropped.
- R12: `busy` is high whenever a packet is queued or being sent, and low otherwise.
- R13: Each channel's parameters 0/1 sit at 0x14+4*(n-1) and parameters 2/3 at 0x24+4*(n-1). The lower-numbered parameter is in bits 15:0, and each parameter register reads back as written.
- R14: `ser_clk` is low when idle, and `ser_data` changes only while `ser_clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | Access is a write when high |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data, valid on rising `ser_clk` |
| busy | output | 1 | Packet queued or in flight |

## Verification
Two functions can fall in the same cycle: a software timer clear and a packet acceptance. Both decide the timestamp in the packet. The bench provokes the overlap by writing a command and then, on the very next edge, writing the configuration word with the clear bit. The accepted packet must then carry a timestamp of 0. In a companion case the clear comes one edge before the command write, and that packet must carry 1. A second overlap is a command write to a channel in the same cycle that another channel's packet is accepted. It is judged through the queue read-back and through the order of packets on the serial line.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int NCH    = 3;
  localparam int HDR_W  = 8;
  localparam int PAR_W  = 16;
  localparam int NPAR   = 4;
  localparam int TS_W   = 16;
  localparam int CNT_W  = 3;
  localparam int PRE_W  = 2;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int PKT_W  = HDR_W + TS_W + NPAR * PAR_W;
  localparam int BITS_W = $clog2(PKT_W + 1);

  localparam logic [ADDR_W-1:0] ADR_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_PLO  = 6'h14;
  localparam logic [ADDR_W-1:0] ADR_PHI  = 6'h24;
  localparam int                CLR_BIT = 6;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic             ts_en;
    logic [1:0]       en3;
    logic [1:0]       en2;
    logic             en1;
  } cfg_t;

  typedef struct packed {
    logic [HDR_W-1:0] hdr;
    logic [CNT_W-1:0] cnt;
  } cmd_t;
endpackage

// File: rtl/trc_regs.sv
module trc_regs
  import trc_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_valid,
  input  logic                                bus_write,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [DATA_W-1:0]                   bus_wdata,
  output logic [DATA_W-1:0]                   bus_rdata,
  input  logic                                accept,
  input  logic [NCH-1:0]                      grant,
  output cfg_t                                cfg,
  output logic                                ts_clr,
  output logic [NCH-1:0]                      pending,
  output cmd_t [NCH-1:0]                      cmd,
  output logic [NCH-1:0][NPAR-1:0][PAR_W-1:0] par
);
  logic           wr;
  logic [NCH-1:0] ch_on;

  assign wr     = bus_valid & bus_write;
  assign ts_clr = wr && (bus_addr == ADR_CFG) && bus_wdata[CLR_BIT];

  always_comb begin
    ch_on[0] = cfg.en1;
    ch_on[1] = |cfg.en2;
    ch_on[2] = |cfg.en3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr && bus_addr == ADR_CFG) begin
      cfg.presc <= bus_wdata[8:7];
      cfg.ts_en <= bus_wdata[5];
      cfg.en3   <= bus_wdata[4:3];
      cfg.en2   <= bus_wdata[2:1];
      cfg.en1   <= bus_wdata[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CMD = ADR_CMD + ADDR_W'(4 * i);
    localparam logic [ADDR_W-1:0] A_PLO = ADR_PLO + ADDR_W'(4 * i);
    localparam logic [ADDR_W-1:0] A_PHI = ADR_PHI + ADDR_W'(4 * i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
        cmd[i]     <= '0;
      end else if (accept && grant[i]) begin
        pending[i] <= 1'b0;
        cmd[i]     <= '0;
      end else if (wr && bus_addr == A_CMD && ch_on[i] && !pending[i]) begin
        pending[i]  <= 1'b1;
        cmd[i].hdr  <= bus_wdata[15:8];
        cmd[i].cnt  <= bus_wdata[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        par[i] <= '0;
      end else if (wr && bus_addr == A_PLO) begin
        par[i][0] <= bus_wdata[PAR_W-1:0];
        par[i][1] <= bus_wdata[2*PAR_W-1:PAR_W];
      end else if (wr && bus_addr == A_PHI) begin
        par[i][2] <= bus_wdata[PAR_W-1:0];
        par[i][3] <= bus_wdata[2*PAR_W-1:PAR_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_CFG)
      bus_rdata[8:0] = {cfg.presc, 1'b0, cfg.ts_en, cfg.en3, cfg.en2, cfg.en1};
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADR_CMD + ADDR_W'(4 * i))
        bus_rdata[15:0] = {cmd[i].hdr, 5'b0, cmd[i].cnt};
      if (bus_addr == ADR_PLO + ADDR_W'(4 * i))
        bus_rdata = {par[i][1], par[i][0]};
      if (bus_addr == ADR_PHI + ADDR_W'(4 * i))
        bus_rdata = {par[i][3], par[i][2]};
    end
  end
endmodule

// File: rtl/trc_timer.sv
module trc_timer
  import trc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic [TS_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else          value <= value + 1'b1;
  end
endmodule

// File: rtl/trc_arbiter.sv
module trc_arbiter
  import trc_pkg::*;
(
  input  logic [NCH-1:0] pending,
  input  logic           idle,
  output logic [NCH-1:0] grant,
  output logic           accept
);
  logic found;
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (pending[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    accept = idle & found;
  end
endmodule

// File: rtl/trc_shifter.sv
module trc_shifter
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PRE_W-1:0]  presc,
  input  logic [PKT_W-1:0]  load_word,
  input  logic [BITS_W-1:0] nbits,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              active
);
  logic [PKT_W-1:0]  sreg;
  logic [BITS_W-1:0] left;
  logic [PRE_W-1:0]  half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ser_clk <= 1'b0;
      sreg    <= '0;
      left    <= '0;
      half    <= '0;
    end else if (!active) begin
      ser_clk <= 1'b0;
      if (start) begin
        active <= 1'b1;
        sreg   <= load_word;
        left   <= nbits;
        half   <= '0;
      end
    end else if (half == presc) begin
      half <= '0;
      if (!ser_clk) begin
        ser_clk <= 1'b1;
      end else begin
        ser_clk <= 1'b0;
        sreg    <= sreg << 1;
        left    <= left - 1'b1;
        if (left == BITS_W'(1)) active <= 1'b0;
      end
    end else begin
      half <= half + 1'b1;
    end
  end

  assign ser_data = active & sreg[PKT_W-1];
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              busy
);
  cfg_t                                cfg;
  logic                                ts_clr;
  logic [NCH-1:0]                      pend_w;
  cmd_t [NCH-1:0]                      cmd;
  logic [NCH-1:0][NPAR-1:0][PAR_W-1:0] par;
  logic [NCH-1:0]                      grant;
  logic                                accept;
  logic                                active;
  logic [TS_W-1:0]                     timer;

  cmd_t                                sel_cmd;
  logic [NPAR-1:0][PAR_W-1:0]          sel_par;
  logic [CNT_W-1:0]                    cnt_c;
  logic [TS_W-1:0]                     ts_snap;
  logic [NPAR*PAR_W-1:0]               pstream;
  logic [PKT_W-1:0]                    load_word;
  logic [BITS_W-1:0]                   nbits;

  trc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .accept(accept), .grant(grant), .cfg(cfg), .ts_clr(ts_clr),
    .pending(pend_w), .cmd(cmd), .par(par)
  );

  trc_timer u_timer (.clk(clk), .rst_n(rst_n), .clr(ts_clr), .value(timer));

  trc_arbiter u_arb (.pending(pend_w), .idle(!active), .grant(grant), .accept(accept));

  always_comb begin
    sel_cmd = '0;
    sel_par = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        sel_cmd = sel_cmd | cmd[i];
        sel_par = sel_par | par[i];
      end
    end
    cnt_c   = (sel_cmd.cnt > CNT_W'(NPAR)) ? CNT_W'(NPAR) : sel_cmd.cnt;
    ts_snap = ts_clr ? '0 : timer;
    for (int k = 0; k < NPAR; k++)
      pstream[(NPAR-k)*PAR_W-1 -: PAR_W] = sel_par[k];
    if (cfg.ts_en) load_word = {sel_cmd.hdr, ts_snap, pstream};
    else           load_word = {sel_cmd.hdr, pstream, {TS_W{1'b0}}};
    nbits = BITS_W'(HDR_W) + (cfg.ts_en ? BITS_W'(TS_W) : '0)
          + BITS_W'(cnt_c) * BITS_W'(PAR_W);
  end

  trc_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .presc(cfg.presc),
    .load_word(load_word), .nbits(nbits), .ser_clk(ser_clk),
    .ser_data(ser_data), .active(active)
  );

  assign busy = active | (|pend_w);
endmodule

// File: rtl/trc_checker.sv
module trc_checker
  import trc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ser_clk,
  input logic            ser_data,
  input logic            active,
  input logic [NCH-1:0]  pending,
  input logic [NCH-1:0]  grant,
  input logic            accept,
  input logic            ts_clr,
  input logic [TS_W-1:0] timer
);
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!ser_clk && !ser_data)); // R14
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data)); // R14
  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pending[0]) |-> grant[0]); // R9
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grant[0]) |=> !pending[0]); // R6
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> active); // R7
  AST_TIMER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clr |=> (timer == '0)); // R4
  AST_TIMER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_clr |=> (timer == TS_W'($past(timer) + 1))); // R4
endmodule

bind trace_serializer trc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
  .active(active), .pending(pend_w), .grant(grant), .accept(accept),
  .ts_clr(ts_clr), .timer(timer)
);

// File: tb/test_trace_serializer.sv
module test_trace_serializer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_clk, ser_data, busy;

  int n_chk = 0, n_fail = 0, cyc = 0, rx_n = 0, exp_n = 0;
  bit done = 0;
  logic rx_bits [0:127];
  int   rise_t  [0:127];
  logic exp_bits[0:127];
  logic prev_sclk = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  trace_serializer i_trace_serializer (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy)
  );

  always @(negedge clk) begin
    if (ser_clk && !prev_sclk) begin
      if (rx_n < 128) begin
        rx_bits[rx_n] = ser_data;
        rise_t[rx_n]  = cyc;
      end
      rx_n++;
    end
    prev_sclk = ser_clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic clear_rx();
    rx_n = 0; exp_n = 0;
  endtask

  task automatic add_bits(input logic [15:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      exp_bits[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic check_stream(input string req);
    int bad = -1;
    chk({req, " bit count"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      if (bad < 0 && rx_bits[i] !== exp_bits[i]) bad = i;
    chk({req, " first bad bit index"}, bad, -1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    foreach (i_addr[k]) begin
      rd(i_addr[k], d);
      chk("R1 reg reset", d, 0);
    end
    chk("R1 ser_clk", ser_clk, 0);
    chk("R1 ser_data", ser_data, 0);
    chk("R1 busy", busy, 0);
  endtask
  logic [5:0] i_addr [0:9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h14, 6'h18, 6'h1C, 6'h24, 6'h28, 6'h2C};

  task automatic t_cfg_layout();
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d);
    chk("R2 cfg readback, clear bit reads 0 (R4)", d, 32'h0000_01BF);
    wr(6'h00, 32'h0);
  endtask

  task automatic t_params();
    logic [31:0] d;
    wr(6'h18, 32'hBEEF_1234);
    wr(6'h2C, 32'hCAFE_0042);
    rd(6'h18, d); chk("R13 ch2 par01", d, 32'hBEEF_1234);
    rd(6'h2C, d); chk("R13 ch3 par23", d, 32'hCAFE_0042);
    rd(6'h14, d); chk("R13 ch1 par01 untouched", d, 0);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    clear_rx();
    wr(6'h00, 32'h0);
    wr(6'h04, 32'h0000_AB03);
    rd(6'h04, d); chk("R5 cmd write ignored", d, 0);
    chk("R5 busy stays low", busy, 0);
    repeat (20) @(negedge clk);
    chk("R5 no bits sent", rx_n, 0);
  endtask

  task automatic t_basic();
    clear_rx();
    wr(6'h00, 32'h1);
    wr(6'h14, 32'h5678_1234);
    wr(6'h24, 32'hDEF0_9ABC);
    wr(6'h04, 32'h0000_A503);
    wait_idle();
    add_bits(16'hA5, 8); add_bits(16'h1234, 16); add_bits(16'h5678, 16); add_bits(16'h9ABC, 16);
    check_stream("R7 hdr+3 params");
    chk("R3 bit period presc0", rise_t[1] - rise_t[0], 2);
    chk("R12 busy low after", busy, 0);
  endtask

  task automatic t_presc();
    clear_rx();
    wr(6'h00, 32'h0000_0101);
    wr(6'h04, 32'h0000_8100);
    wait_idle();
    add_bits(16'h81, 8);
    check_stream("R8 count 0 header only");
    chk("R3 bit period presc2", rise_t[1] - rise_t[0], 6);
  endtask

  task automatic t_clamp();
    clear_rx();
    wr(6'h00, 32'h1);
    wr(6'h04, 32'h0000_3C07);
    wait_idle();
    add_bits(16'h3C, 8); add_bits(16'h1234, 16); add_bits(16'h5678, 16);
    add_bits(16'h9ABC, 16); add_bits(16'hDEF0, 16);
    check_stream("R8 count 7 clamps to 4");
  endtask

  task automatic t_ts();
    clear_rx();
    wr(6'h00, 32'h0000_0061);
    wr(6'h04, 32'h0000_1101);
    wait_idle();
    add_bits(16'h11, 8); add_bits(16'h0001, 16); add_bits(16'h1234, 16);
    check_stream("R4 timestamp one after clear");
  endtask

  task automatic t_collide();
    clear_rx();
    wr(6'h04, 32'h0000_2200);
    wr(6'h00, 32'h0000_0061);
    wait_idle();
    add_bits(16'h22, 8); add_bits(16'h0000, 16);
    check_stream("R4 clear same cycle as accept");
  endtask

  task automatic t_queue();
    logic [31:0] d;
    clear_rx();
    wr(6'h00, 32'h0000_000D);
    wr(6'h1C, 32'h0000_7777);
    wr(6'h0C, 32'h0000_3301);
    wr(6'h08, 32'h0000_2200);
    wr(6'h08, 32'h0000_9902);
    wr(6'h04, 32'h0000_1100);
    wr(6'h1C, 32'h0000_1111);
    rd(6'h08, d); chk("R6 ch2 waits with fields", d, 32'h0000_2200);
    rd(6'h0C, d); chk("R6 ch3 cleared on accept", d, 0);
    chk("R12 busy while queued", busy, 1);
    wait_idle();
    add_bits(16'h33, 8); add_bits(16'h7777, 16);
    add_bits(16'h11, 8);
    add_bits(16'h22, 8);
    check_stream("R9 R10 R11 order and latched params");
    rd(6'h08, d); chk("R6 ch2 cleared after send", d, 0);
    rd(6'h1C, d); chk("R13 ch3 par readback", d, 32'h0000_1111);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_cfg_layout();
    t_params();
    t_gating();
    t_basic();
    t_presc();
    t_clamp();
    t_ts();
    t_collide();
    t_queue();
    summary();
  end
endmodule